// File: doc/BRIEF.md
# PCI Initiator Target-Claim Watchdog

This block sits beside the state machine of a PCI initiator and checks that some target claims every transaction the initiator starts. It samples the initiator's own FRAME# and IRDY# together with the bus DEVSEL#, TRDY# and STOP# lines. It counts clocks from the address phase and requests a master-abort when no claim shows up in time. When a claim arrives, it records how many clocks the target took to decode, so fast, medium, slow and subtractive claims can be told apart.

The address-phase edge is the rising clock edge at which FRAME# is sampled asserted while the watchdog is idle. Counting starts there. The claim window runs over the four edges that follow. Once a transaction has been claimed or aborted, the watchdog waits until FRAME# and IRDY# are both sampled deasserted before it accepts a new address phase. Each transaction of a back-to-back stream is therefore timed on its own. All bus inputs are active low.

Top module: `pci_claim_watchdog`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises, every output is 0: timing, claim_vld, claim_speed, abort_req, rma_sts and proto_err.
- R2: The first edge at which DEVSEL# is sampled low is edge k after the address-phase edge, with k from 1 to 4. From that edge on, claim_vld is 1 and claim_speed holds k-1: 00 fast (k=1), 01 medium (k=2), 10 slow (k=3), 11 subtractive (k=4). Both hold until the next address-phase edge, which clears claim_vld.
- R3: A transaction claimed on edge 1 to 4 never raises abort_req. The counter stops at the claim edge, and timing falls at that edge.
- R4: If DEVSEL# is sampled high on all of edges 1 to 4, abort_req is 1 for exactly the one cycle that follows edge 4, and timing falls at edge 4. A DEVSEL# that first arrives on edge 5 or later leaves claim_vld at 0.
- R5: rma_sts is set at the same edge as abort_req and then stays set. An edge with rma_clr high clears it, except that an abort at that same edge wins and leaves it set.
- R6: proto_err is 1 for the cycle after any edge where the watchdog is timing, DEVSEL# is sampled high, and TRDY# or STOP# is sampled low. TRDY# or STOP# arriving at the same edge as DEVSEL#, or after it, is not flagged.
- R7: After a claim or an abort, FRAME# sampled low is ignored until one edge has sampled FRAME# and IRDY# both high. Until then, timing stays 0, no abort occurs and the claim result is kept.
- R8: While idle, a DEVSEL#, TRDY# or STOP# assertion changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Initiator's own FRAME#, active low |
| irdy_n | input | 1 | Initiator's own IRDY#, active low |
| devsel_n | input | 1 | Bus DEVSEL#, active low |
| trdy_n | input | 1 | Bus TRDY#, active low |
| stop_n | input | 1 | Bus STOP#, active low |
| rma_clr | input | 1 | Write-one-to-clear for rma_sts |
| timing | output | 1 | Watchdog is counting the claim window |
| claim_vld | output | 1 | The current transaction was claimed |
| claim_speed | output | 2 | Claim class: 00 fast, 01 medium, 10 slow, 11 subtractive |
| abort_req | output | 1 | One-cycle master-abort request |
| proto_err | output | 1 | One-cycle flag: TRDY# or STOP# came before DEVSEL# |
| rma_sts | output | 1 | Sticky received-master-abort status |

## Verification
The claim delay is swept from 1 to 5 clocks, with no claim as a sixth case. Delays 1 to 4 must produce the four speed codes and no abort. Delay 5 and no claim must both produce the abort, which shows that the deadline sits exactly at edge 4. Every one of those delays is crossed with an early TRDY# or STOP# at each edge of the window. These cases separate a premature target response from one that is coincident or late. Separate sequences hold IRDY# low to show that re-arming is blocked, pulse DEVSEL# while idle, and hold the clear input through an abort to show that set wins over clear.

// File: rtl/pci_claim_watchdog.sv
module pci_claim_watchdog #(
  parameter int ABORT_CLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       devsel_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic       rma_clr,
  output logic       timing,
  output logic       claim_vld,
  output logic [1:0] claim_speed,
  output logic       abort_req,
  output logic       proto_err,
  output logic       rma_sts
);
  localparam int CW = $clog2(ABORT_CLKS + 1);

  logic          armed, done;
  logic [CW-1:0] cnt;

  wire start    = ~armed & ~done & ~frame_n;
  wire hit      = armed & ~devsel_n;
  wire expire   = armed & devsel_n & (cnt == CW'(ABORT_CLKS));
  wire bus_idle = frame_n & irdy_n;
  wire early    = armed & devsel_n & (~trdy_n | ~stop_n);

  assign timing = armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      done        <= 1'b0;
      cnt         <= '0;
      claim_vld   <= 1'b0;
      claim_speed <= 2'd0;
      abort_req   <= 1'b0;
      proto_err   <= 1'b0;
      rma_sts     <= 1'b0;
    end else begin
      abort_req <= expire;
      proto_err <= early;
      if (expire)       rma_sts <= 1'b1;
      else if (rma_clr) rma_sts <= 1'b0;

      if (start) begin
        armed     <= 1'b1;
        cnt       <= CW'(1);
        claim_vld <= 1'b0;
      end else if (armed) begin
        if (hit) begin
          armed       <= 1'b0;
          done        <= 1'b1;
          claim_vld   <= 1'b1;
          claim_speed <= (cnt > CW'(3)) ? 2'd3 : 2'(cnt - CW'(1));
        end else if (expire) begin
          armed <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else if (done && bus_idle) begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pci_claim_watchdog_chk.sv
module pci_claim_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       rma_clr,
  input logic       timing,
  input logic       claim_vld,
  input logic [1:0] claim_speed,
  input logic       abort_req,
  input logic       proto_err,
  input logic       rma_sts
);
  // R4
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  // R5
  abort_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> rma_sts);

  // R5
  sts_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rma_sts) |-> $past(rma_clr));

  // R2
  claim_needs_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim_vld) |-> !$past(devsel_n));

  // R2
  speed_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vld && $past(claim_vld)) |-> $stable(claim_speed));

  // R3
  claim_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !claim_vld);

  // R6
  proto_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> ($past(devsel_n) && (!$past(trdy_n) || !$past(stop_n))));

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing) |-> !$past(frame_n));
endmodule

bind pci_claim_watchdog pci_claim_watchdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .devsel_n(devsel_n),
  .trdy_n(trdy_n), .stop_n(stop_n), .rma_clr(rma_clr), .timing(timing),
  .claim_vld(claim_vld), .claim_speed(claim_speed), .abort_req(abort_req),
  .proto_err(proto_err), .rma_sts(rma_sts)
);

// File: tb/pci_claim_watchdog_tb_top.sv
module pci_claim_watchdog_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
  logic rma_clr = 1'b0;
  logic timing, claim_vld, abort_req, proto_err, rma_sts;
  logic [1:0] claim_speed;

  int checks = 0, errors = 0;
  bit rma_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pci_claim_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .rma_clr(rma_clr),
    .timing(timing), .claim_vld(claim_vld), .claim_speed(claim_speed),
    .abort_req(abort_req), .proto_err(proto_err), .rma_sts(rma_sts)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // d: claim edge (0 = never); te: edge of early TRDY#/STOP# (0 = none)
  task automatic run_txn(int d, int te, bit use_stop, bit clr_hold, bit hold_irdy);
    bit ok = (d >= 1 && d <= 4);
    @(negedge clk);
    frame_n = 1'b0;
    rma_clr = clr_hold;
    for (int k = 1; k <= 7; k++) begin
      int j;
      @(negedge clk);
      j = k - 1;
      if (j == 4 && !ok) rma_m = 1'b1;
      else if (clr_hold) rma_m = 1'b0;
      check("R4 abort_req", abort_req, (j == 4 && !ok) ? 1 : 0);
      check("R3 timing", timing, (j < (ok ? d : 4)) ? 1 : 0);
      check("R2 claim_vld", claim_vld, (ok && j >= d) ? 1 : 0);
      if (ok && j >= d) check("R2 claim_speed", claim_speed, d - 1);
      check("R6 proto_err", proto_err,
            (j >= 1 && j == te && te <= 4 && (d == 0 || te < d)) ? 1 : 0);
      check("R5 rma_sts", rma_sts, rma_m);
      if (k <= 6) begin
        frame_n  = 1'b1;
        irdy_n   = 1'b0;
        devsel_n = !(d != 0 && k >= d);
        trdy_n   = !(k == te && !use_stop);
        stop_n   = !(k == te && use_stop);
      end else begin
        devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; frame_n = 1'b1;
        irdy_n = hold_irdy ? 1'b0 : 1'b1;
        rma_clr = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 timing", timing, 0);
    check("R1 claim_vld", claim_vld, 0);
    check("R1 claim_speed", claim_speed, 0);
    check("R1 abort_req", abort_req, 0);
    check("R1 proto_err", proto_err, 0);
    check("R1 rma_sts", rma_sts, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {timing, claim_vld, abort_req, rma_sts}, 0);

    // R2 R3 R4 R6: sweep claim delay x early response edge x signal
    for (int d = 0; d <= 5; d++)
      for (int te = 0; te <= 4; te++)
        for (int s = 0; s <= 1; s++)
          run_txn(d, te, s[0], 1'b0, 1'b0);

    // R5: clear with one-cycle pulse
    @(negedge clk); rma_clr = 1'b1;
    @(negedge clk); rma_clr = 1'b0; rma_m = 1'b0;
    check("R5 cleared", rma_sts, 0);
    // R5: clear held through an abort; abort wins at its edge
    run_txn(0, 0, 1'b0, 1'b1, 1'b0);

    // R7: re-arm blocked while IRDY# stays low after a claim
    run_txn(2, 0, 1'b0, 1'b0, 1'b1);
    frame_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R7 no rearm timing", timing, 0);
      check("R7 no rearm abort", abort_req, 0);
      check("R7 claim kept", claim_vld, 1);
      check("R7 speed kept", claim_speed, 1);
    end
    frame_n = 1'b1; irdy_n = 1'b1;
    @(negedge clk);
    run_txn(3, 0, 1'b0, 1'b0, 1'b0);

    // R8: target signals while idle change nothing
    devsel_n = 1'b0; trdy_n = 1'b0; stop_n = 1'b0;
    @(negedge clk);
    devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
    @(negedge clk);
    check("R8 idle timing", timing, 0);
    check("R8 idle claim", claim_vld, 1);
    check("R8 idle speed", claim_speed, 2);
    check("R8 idle proto", proto_err, 0);
    check("R8 idle abort", abort_req, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule